// File: doc/BRIEF.md
# Sector Hamming ECC Generator

This block computes a three-byte Hamming-style check code over one data sector, taking one byte per clock. A sector is opened by a one-cycle start pulse; each byte presented with the valid strobe high is numbered from zero upward. After the last byte of the sector (byte index 511 with the default 512-byte sector) is taken, the block raises a one-cycle done pulse and presents the packed code on three output bytes. The code stays on those outputs until the next sector completes.

Internally the block keeps two accumulators. The first is the XOR of every accepted byte, which gives the column parities. The second is the XOR of the 9-bit index of every accepted byte with odd bit parity, which gives the row parities. When the sector ends the two are combined: the prime row parities are the row accumulator with every bit flipped when the column XOR has odd parity. The column parities come from masked reductions of the column XOR. Everything is packed into the three bytes and inverted.

Control is a three-state machine. ST_IDLE means no sector is open and bytes are ignored. ST_COLLECT means a sector is being accumulated. ST_FINISH lasts one cycle and drives the done pulse. The transitions are as follows:
- start moves any state to ST_COLLECT.
- Taking the final byte moves ST_COLLECT to ST_FINISH.
- ST_FINISH falls back to ST_IDLE on its own.
- Start has priority over completion.

Top module: `sector_ecc_gen`

## Requirements
- R1: After reset, done_o is 0 and ecc2_o, ecc1_o and ecc0_o are each 8'hFF.
- R2: start_i clears both accumulators and the byte index. A byte presented with valid_i high in the same cycle as start_i is taken as index 0 of the new sector, even when it would otherwise have been the final byte of the previous sector. Such a byte does not complete that earlier sector.
- R3: A byte is ignored when valid_i is low, or when no sector is open (before the first start, or after a sector has completed and before the next start). An ignored byte does not change the code of the next completed sector, and it does not raise done_o.
- R4: done_o is high for exactly one cycle, the cycle after the clock edge that takes byte index SECTOR_BYTES-1 of an open sector.
- R5: Row parity: the row value is the XOR of the 9-bit index of every taken byte with an odd number of 1 bits. The prime row value is that row value XOR 9 copies of the parity of the column XOR.
- R6: Column parities come from the XOR C of all taken bytes. P4 is the parity of C&8'hF0, P4' of C&8'h0F, P2 of C&8'hCC, P2' of C&8'h33, P1 of C&8'hAA and P1' of C&8'h55.
- R7: Before inversion, ecc2 bits 7..2 are P4, P4', P2, P2', P1, P1'. Bit 1 is row bit 8 and bit 0 is prime row bit 8.
- R8: Before inversion, ecc1 bits 7..0 are row7, prime7, row6, prime6, row5, prime5, row4, prime4. ecc0 bits 7..0 are row3, prime3, down to row0, prime0.
- R9: All three output bytes are the bitwise inverse of the packed values in R7 and R8. An all-zero sector yields FF FF FF.
- R10: The ECC outputs change only in the cycle where done_o is high. They hold through later starts and ignored bytes until the next sector completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new sector, clearing accumulators and index |
| valid_i | input | 1 | data_i holds a sector byte this cycle |
| data_i | input | 8 | Sector byte |
| ecc0_o | output | 8 | Code byte 0 (row bits 3..0 and primes, inverted) |
| ecc1_o | output | 8 | Code byte 1 (row bits 7..4 and primes, inverted) |
| ecc2_o | output | 8 | Code byte 2 (column parities, row bit 8 and prime, inverted) |
| done_o | output | 1 | One-cycle pulse when the sector's final byte has been taken |

## Verification
The start pulse and the taking of a byte can fall in the same cycle, and so can the start pulse and the final byte of a sector that is still open. The bench provokes the first case by opening sectors with start and valid high together. It provokes the second by feeding 511 bytes and then asserting start alongside the next byte. The scoreboard expects no done for the abandoned sector and one code for the new sector, with that shared byte counted at index 0. Any extra or missing done pulse, or a code that does not match, is reported.

// File: rtl/sector_ecc_pkg.sv
package sector_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FINISH  = 2'd2
    } ecc_state_t;

    function automatic logic odd8(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/sector_ecc_ctrl.sv
module sector_ecc_ctrl
    import sector_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int IDX_W        = $clog2(SECTOR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    output logic             take_o,
    output logic             clear_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             capture_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

    ecc_state_t       state_q, state_d;
    logic [IDX_W-1:0] count_q;
    logic             last_take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         count_q <= '0;
        else if (last_take) count_q <= '0;
        else if (take_o)    count_q <= idx_o + IDX_W'(1);
        else if (start_i)   count_q <= '0;
    end

    // Datapath control outputs
    always_comb begin
        clear_o   = start_i;
        take_o    = valid_i && (start_i || state_q == ST_COLLECT);
        idx_o     = start_i ? '0 : count_q;
        last_take = take_o && (idx_o == LAST_IDX);
        capture_o = last_take;
        done_o    = (state_q == ST_FINISH);
    end

    // Next state: completion first, then start, then hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_COLLECT;
            ST_COLLECT: state_d = ST_COLLECT;
            ST_FINISH:  state_d = start_i ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (last_take) state_d = ST_FINISH;
    end

    // R4: done never lasts longer than one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: the index stays at zero while no sector is open
    a_r3_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COLLECT) |-> (count_q == '0));

    // R2: a start that does not finish a sector leaves a sector open
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !last_take) |=> (state_q == ST_COLLECT));

endmodule

// File: rtl/sector_ecc_accum.sv
module sector_ecc_accum
    import sector_ecc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] col_nxt_o,
    output logic [IDX_W-1:0]  row_nxt_o
);

    logic [DATA_W-1:0] col_q, col_base;
    logic [IDX_W-1:0]  row_q, row_base;

    always_comb begin
        col_base  = clear_i ? '0 : col_q;
        row_base  = clear_i ? '0 : row_q;
        col_nxt_o = col_base ^ (take_i ? data_i : '0);
        row_nxt_o = row_base ^ ((take_i && odd8(data_i)) ? idx_i : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            col_q <= col_nxt_o;
            row_q <= row_nxt_o;
        end
    end

    // R2: a start with no byte leaves both accumulators empty
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !take_i) |=> (col_q == '0 && row_q == '0));

    // R3: with no byte taken and no start the accumulators hold
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !take_i) |=> ($stable(col_q) && $stable(row_q)));

endmodule

// File: rtl/sector_ecc_pack.sv
module sector_ecc_pack
    import sector_ecc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [7:0]       col_i,
    input  logic [IDX_W-1:0] row_i,
    output logic [7:0]       ecc0_o,
    output logic [7:0]       ecc1_o,
    output logic [7:0]       ecc2_o
);

    localparam int PAIRS = IDX_W - 1;

    logic             col_odd;
    logic [IDX_W-1:0] prime;
    logic [5:0]       colpar;
    logic [2*PAIRS-1:0] weave;
    logic [7:0]       ecc0_d, ecc1_d, ecc2_d;

    always_comb begin
        col_odd = odd8(col_i);
        prime   = row_i ^ {IDX_W{col_odd}};
        colpar  = { odd8(col_i & 8'hF0), odd8(col_i & 8'h0F),
                    odd8(col_i & 8'hCC), odd8(col_i & 8'h33),
                    odd8(col_i & 8'hAA), odd8(col_i & 8'h55) };
    end

    // Row bit above its prime, pair by pair
    for (genvar k = 0; k < PAIRS; k++) begin : g_weave
        assign weave[2*k+1] = row_i[k];
        assign weave[2*k]   = prime[k];
    end

    always_comb begin
        ecc0_d = ~weave[7:0];
        ecc1_d = ~weave[15:8];
        ecc2_d = ~{colpar, row_i[IDX_W-1], prime[IDX_W-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecc0_o <= 8'hFF;
            ecc1_o <= 8'hFF;
            ecc2_o <= 8'hFF;
        end else if (capture_i) begin
            ecc0_o <= ecc0_d;
            ecc1_o <= ecc1_d;
            ecc2_o <= ecc2_d;
        end
    end

endmodule

// File: rtl/sector_ecc_gen.sv
module sector_ecc_gen
    import sector_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [7:0]        ecc0_o,
    output logic [7:0]        ecc1_o,
    output logic [7:0]        ecc2_o,
    output logic              done_o
);

    localparam int IDX_W = $clog2(SECTOR_BYTES);

    logic              take, clear, capture;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] col_nxt;
    logic [IDX_W-1:0]  row_nxt;

    sector_ecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .take_o(take), .clear_o(clear), .idx_o(idx),
        .capture_o(capture), .done_o(done_o)
    );

    sector_ecc_accum #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .take_i(take),
        .idx_i(idx), .data_i(data_i),
        .col_nxt_o(col_nxt), .row_nxt_o(row_nxt)
    );

    sector_ecc_pack #(.IDX_W(IDX_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .capture_i(capture),
        .col_i(col_nxt), .row_i(row_nxt),
        .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o)
    );

    // R10: the code moves only together with the done pulse
    a_r10_code_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o)) |-> done_o);

    // R4: done follows a cycle in which a byte was presented
    a_r4_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i));

endmodule

// File: tb/sector_ecc_gen_bench.sv
module sector_ecc_gen_bench;

    localparam int N = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] ecc0_o, ecc1_o, ecc2_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int done_want = 0;
    logic prev_done = 1'b0;
    logic [23:0] last_code = 24'hFFFFFF;
    logic [7:0] sec [N];
    logic [23:0] expq [$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;   // 250 MHz

    sector_ecc_gen u_sector_ecc_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o),
        .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit par8(input logic [7:0] b);
        return ^b;
    endfunction

    // Reference code per R5..R9, returned as {ecc2, ecc1, ecc0}
    function automatic logic [23:0] model();
        logic [7:0] c = 8'h00;
        logic [8:0] r = 9'h000;
        logic [8:0] p;
        logic [7:0] e0, e1, e2;
        for (int i = 0; i < N; i++) begin
            c ^= sec[i];
            if (par8(sec[i])) r ^= 9'(i);
        end
        p = r ^ {9{par8(c)}};
        e2 = {par8(c & 8'hF0), par8(c & 8'h0F), par8(c & 8'hCC), par8(c & 8'h33),
              par8(c & 8'hAA), par8(c & 8'h55), r[8], p[8]};
        for (int k = 0; k < 4; k++) begin
            e1[2*k+1] = r[k+4]; e1[2*k] = p[k+4];
            e0[2*k+1] = r[k];   e0[2*k] = p[k];
        end
        return ~{e2, e1, e0};
    endfunction

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    // Drive bytes [from, to) of sec; optional start with first; gaps insert idle junk
    task automatic drive(input int from, input int to, input bit with_start, input int gap);
        for (int i = from; i < to; i++) begin
            if (gap != 0 && (i % gap) == 1) begin
                @(negedge clk);
                start_i = 1'b0; valid_i = 1'b0; data_i = next_rand(); // R3 junk
            end
            @(negedge clk);
            start_i = with_start && (i == from);
            valid_i = 1'b1;
            data_i  = sec[i];
        end
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; data_i = 8'h00;
    endtask

    task automatic send_sector(input logic [23:0] exp, input int gap);
        expq.push_back(exp);
        done_want++;
        drive(0, N, 1'b1, gap);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < N; i++) begin
            case (kind)
                0: sec[i] = 8'h00;
                1: sec[i] = next_rand();
                2: sec[i] = 8'(i) ^ 8'(i >> 3);
                default: sec[i] = 8'hFF;
            endcase
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done)
                check(1'b0, "R4 done longer than one cycle", 32'd1, 32'd0);
            if (done_o) begin
                done_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, "R4 unexpected done", 32'd1, 32'd0);
                end else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    check({ecc2_o, ecc1_o, ecc0_o} == e, "R5-code R7 R8 R9",
                          {8'h0, ecc2_o, ecc1_o, ecc0_o}, {8'h0, e});
                end
                last_code = {ecc2_o, ecc1_o, ecc0_o};
            end else begin
                check({ecc2_o, ecc1_o, ecc0_o} == last_code, "R10 code held",
                      {8'h0, ecc2_o, ecc1_o, ecc0_o}, {8'h0, last_code});
            end
        end
        prev_done = done_o;
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic [23:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done at reset", {31'd0, done_o}, 32'd0);
        check({ecc2_o, ecc1_o, ecc0_o} == 24'hFFFFFF, "R1 code at reset",
              {8'h0, ecc2_o, ecc1_o, ecc0_o}, 32'h00FFFFFF);
        rst_n = 1'b1;

        // R3: bytes before any start are ignored
        repeat (5) begin
            @(negedge clk); valid_i = 1'b1; data_i = 8'h5A;
        end
        @(negedge clk); valid_i = 1'b0;
        repeat (2) @(negedge clk);
        check(done_seen == 0, "R3 no done before start", done_seen, 0);

        // R9 all-zero sector
        fill(0);
        send_sector(24'hFFFFFF, 0);

        // R6 R7 R8 R9: single 0x80 at index 0
        fill(0); sec[0] = 8'h80;
        send_sector(24'h56AAAA, 0);

        // R5: single 0x01 at index 511
        fill(0); sec[511] = 8'h01;
        send_sector(24'hA95555, 0);

        // R6: even-parity byte 0x03 at index 3
        fill(0); sec[3] = 8'h03;
        send_sector(24'hF3FFFF, 0);

        // Random sectors, with and without idle gaps (R3)
        fill(1); send_sector(model(), 0);
        fill(1); send_sector(model(), 7);
        fill(2); send_sector(model(), 0);
        fill(3); send_sector(model(), 3);

        // R3 R10: bytes after completion ignored, code held
        held = last_code;
        repeat (20) begin
            @(negedge clk); valid_i = 1'b1; data_i = next_rand();
        end
        @(negedge clk); valid_i = 1'b0;
        repeat (2) @(negedge clk);
        check(last_code == held && done_seen == done_want, "R3 late bytes ignored",
              {8'h0, last_code}, {8'h0, held});

        // R2: abort mid-sector with a bare start, then a full sector
        fill(1);
        drive(0, 200, 1'b1, 0);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check({ecc2_o, ecc1_o, ecc0_o} == held, "R10 code held over start",
              {8'h0, ecc2_o, ecc1_o, ecc0_o}, {8'h0, held});
        fill(1); send_sector(model(), 0);

        // R2: start coincides with what would be the final byte
        fill(1);
        drive(0, N - 1, 1'b1, 0);
        fill(1);
        expq.push_back(model());
        done_want++;
        drive(0, N, 1'b1, 0);
        repeat (3) @(negedge clk);
        check(done_seen == done_want, "R2 start over final byte", done_seen, done_want);

        // R4: total done count and empty scoreboard
        check(expq.size() == 0, "R4 all codes produced", expq.size(), 0);
        check(done_seen == done_want, "R4 done count", done_seen, done_want);
        summary();
    end

endmodule